// File: doc/BRIEF.md
# Split Serial Shift Register

This block is the serial side of a dual-port video memory: a 512-word by 16-bit register that is filled from a memory row in one cycle and then drained one word per serial strobe. A full transfer replaces the whole register and sets the read position to any of the 512 words. A split transfer refills only the half that is not being read. This lets a display stream run without a gap while the next row is brought in behind it.

The register is treated as a low half (words 0 to 255) and a high half (words 256 to 511). When the read position leaves the last word of its half, it jumps to the other half. If a split transfer has left a start offset for that half, reading begins there. Otherwise it begins at that half's first word. A one-bit flag reports which half is being read. The memory row arrives on a wide parallel bus supplied by the surrounding logic.

Top module: `serial_split_reg`

## Requirements
- R1: After reset the read position is word 0, `active_half` is 0, every stored word is 0 and no split start offset is pending.
- R2: A full transfer (`xfer_full`=1) stores word k of the register from `row_data[k*16 +: 16]` for every k. It sets the read position to `xfer_tap`, so that `active_half` equals `xfer_tap[8]` after the edge. It discards any pending split start offset.
- R3: `ser_data` always shows the stored word at the read position. Each cycle with `shift_en`=1, where the position is not the last word of its half, moves the position to the next word (255 goes to 256 and 511 goes to 0 only through R4).
- R4: With `shift_en`=1 at offset 255 of a half, the position moves to the other half. It lands at the pending split start offset if one exists, and at that half's first word otherwise. `active_half` toggles on that same edge. Word 511 therefore continues at word 0 when nothing is pending.
- R5: A split transfer (`xfer_split`=1, `xfer_full`=0) loads only the 256 words of the inactive half, each from the same word position of `row_data`. It records `xfer_tap[7:0]` as that half's start offset and ignores `xfer_tap[8]`. The data and read position of the active half are not changed. A newer split replaces an older pending offset.
- R6: When `xfer_split` and `shift_en` are both 1 in the same cycle, the read position advances first. The split then loads the half that is inactive after that advance.
- R7: `xfer_full` takes priority over `xfer_split` and `shift_en` in the same cycle. Both of those are then ignored.
- R8: In a cycle with no strobe and no transfer, `ser_data` and `active_half` hold.
- R9: A pending start offset is used for one half-switch only. A later entry into that half, with no new split transfer, starts at its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Serial strobe: advance the read position one word |
| xfer_full | input | 1 | Full transfer: load all words, set read position |
| xfer_split | input | 1 | Split transfer: load the inactive half, record its start offset |
| xfer_tap | input | 9 | Start word for a full transfer; bits 7:0 give the offset for a split |
| row_data | input | 8192 | Memory row, word k at bits k*16+15 down to k*16 |
| ser_data | output | 16 | Word at the current read position |
| active_half | output | 1 | 0 while the low half is read, 1 while the high half is read |

## Verification
A serial strobe and a split transfer can arrive in the same cycle. The interesting case is the strobe that leaves offset 255, so the half that counts as inactive changes within that cycle. The bench raises both on the last word of the low half. It then checks that the stream enters the high half with its old data, and that the low half later resumes at the new offset with the new row. A second collision, all three controls together, checks that the full transfer wins and leaves no split offset behind.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_FULL  = 2'd1,
        LD_SPLIT = 2'd2
    } load_kind_e;
endpackage

// File: rtl/ssr_tap_ctrl.sv
module ssr_tap_ctrl
    import ssr_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv_i,
    input  logic                     full_i,
    input  logic                     split_i,
    input  logic [$clog2(DEPTH)-1:0] tap_i,
    output logic [$clog2(DEPTH)-1:0] ptr_o,
    output load_kind_e               load_o,
    output logic                     load_half_o
);
    localparam int AW   = $clog2(DEPTH);
    localparam int OW   = AW - 1;
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          pend_vld;
        logic [OW-1:0] pend_off;
    } tap_state_t;

    tap_state_t st_d, st_q;
    logic [AW-1:0] stepped;
    logic          pv;
    logic [OW-1:0] po;

    always_comb begin
        st_d        = st_q;
        load_o      = LD_NONE;
        load_half_o = 1'b0;
        stepped     = st_q.ptr;
        pv          = st_q.pend_vld;
        po          = st_q.pend_off;
        if (adv_i) begin
            if (st_q.ptr[OW-1:0] == OW'(HALF - 1)) begin
                stepped = {~st_q.ptr[AW-1], (pv ? po : {OW{1'b0}})};
                pv      = 1'b0;
            end else begin
                stepped = st_q.ptr + AW'(1);
            end
        end
        if (full_i) begin
            st_d.ptr      = tap_i;
            st_d.pend_vld = 1'b0;
            load_o        = LD_FULL;
        end else begin
            st_d.ptr      = stepped;
            st_d.pend_vld = pv;
            st_d.pend_off = po;
            if (split_i) begin
                load_o        = LD_SPLIT;
                load_half_o   = ~stepped[AW-1];
                st_d.pend_vld = 1'b1;
                st_d.pend_off = tap_i[OW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;
endmodule

// File: rtl/ssr_word_store.sv
module ssr_word_store
    import ssr_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  load_kind_e               load_i,
    input  logic                     half_i,
    input  logic [DEPTH*WIDTH-1:0]   row_i,
    input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
    output logic [WIDTH-1:0]         rd_data_o
);
    localparam int HALF = DEPTH / 2;

    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        case (load_i)
            LD_FULL: begin
                for (int k = 0; k < DEPTH; k++) begin
                    mem_d[k] = row_i[k*WIDTH +: WIDTH];
                end
            end
            LD_SPLIT: begin
                for (int k = 0; k < HALF; k++) begin
                    if (half_i) begin
                        mem_d[k+HALF] = row_i[(k+HALF)*WIDTH +: WIDTH];
                    end else begin
                        mem_d[k] = row_i[k*WIDTH +: WIDTH];
                    end
                end
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/serial_split_reg.sv
module serial_split_reg
    import ssr_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shift_en,
    input  logic                   xfer_full,
    input  logic                   xfer_split,
    input  logic [AW-1:0]          xfer_tap,
    input  logic [DEPTH*WIDTH-1:0] row_data,
    output logic [WIDTH-1:0]       ser_data,
    output logic                   active_half
);
    logic [AW-1:0] ptr_q;
    load_kind_e    load_kind;
    logic          load_half;

    ssr_tap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (shift_en),
        .full_i      (xfer_full),
        .split_i     (xfer_split),
        .tap_i       (xfer_tap),
        .ptr_o       (ptr_q),
        .load_o      (load_kind),
        .load_half_o (load_half)
    );

    ssr_word_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_kind),
        .half_i    (load_half),
        .row_i     (row_data),
        .rd_addr_i (ptr_q),
        .rd_data_o (ser_data)
    );

    assign active_half = ptr_q[AW-1];
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
    parameter int AW    = 9,
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_en,
    input logic             xfer_full,
    input logic             xfer_split,
    input logic [AW-1:0]    xfer_tap,
    input logic [WIDTH-1:0] ser_data,
    input logic             active_half,
    input logic [AW-1:0]    ptr
);
    AST_FULL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_full |=> active_half == $past(xfer_tap[AW-1])); // R2
    AST_FULL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_full |=> ptr == $past(xfer_tap)); // R7
    AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !xfer_full && !(&ptr[AW-2:0])) |=> ptr == AW'($past(ptr) + 1)); // R3
    AST_HALF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !xfer_full && (&ptr[AW-2:0])) |=> active_half != $past(active_half)); // R4
    AST_SPLIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_split && !xfer_full && !shift_en) |=> $stable(ser_data) && $stable(ptr)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !xfer_full) |=> $stable(active_half) && $stable(ser_data)); // R8
endmodule

bind serial_split_reg ssr_checker #(.AW(AW), .WIDTH(WIDTH)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_en    (shift_en),
    .xfer_full   (xfer_full),
    .xfer_split  (xfer_split),
    .xfer_tap    (xfer_tap),
    .ser_data    (ser_data),
    .active_half (active_half),
    .ptr         (ptr_q)
);

// File: tb/test_serial_split_reg.sv
module test_serial_split_reg;
    localparam int DEPTH = 512;
    localparam int WIDTH = 16;
    localparam int AW    = 9;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   shift_en;
    logic                   xfer_full;
    logic                   xfer_split;
    logic [AW-1:0]          xfer_tap;
    logic [DEPTH*WIDTH-1:0] row_data;
    logic [WIDTH-1:0]       ser_data;
    logic                   active_half;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    serial_split_reg i_serial_split_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en    (shift_en),
        .xfer_full   (xfer_full),
        .xfer_split  (xfer_split),
        .xfer_tap    (xfer_tap),
        .row_data    (row_data),
        .ser_data    (ser_data),
        .active_half (active_half)
    );

    function automatic logic [WIDTH-1:0] wv(int k, int s);
        logic [6:0] sv = s[6:0];
        logic [8:0] kv = k[8:0];
        return {sv, kv};
    endfunction

    function automatic logic [DEPTH*WIDTH-1:0] mkrow(int s);
        logic [DEPTH*WIDTH-1:0] r;
        for (int k = 0; k < DEPTH; k++) r[k*WIDTH +: WIDTH] = wv(k, s);
        return r;
    endfunction

    task automatic chk(string req, logic [WIDTH-1:0] ed, logic eh);
        checks++;
        if (ser_data !== ed || active_half !== eh) begin
            fails++;
            $display("FAIL %s: data=%h half=%b expected data=%h half=%b",
                     req, ser_data, active_half, ed, eh);
        end
    endtask

    task automatic cyc(bit a, bit f, bit s, int tap, int seed);
        shift_en   = a;
        xfer_full  = f;
        xfer_split = s;
        xfer_tap   = tap[AW-1:0];
        if (f || s) row_data = mkrow(seed);
        @(negedge clk);
        shift_en   = 1'b0;
        xfer_full  = 1'b0;
        xfer_split = 1'b0;
    endtask

    task automatic adv_n(int n);
        repeat (n) cyc(1'b1, 1'b0, 1'b0, 0, 0);
    endtask

    task automatic t_reset;
        chk("R1 reset", 16'h0000, 1'b0);
    endtask

    task automatic t_full_step;
        cyc(0, 1, 0, 10, 1);
        chk("R2 full load tap 10", wv(10, 1), 1'b0);
        adv_n(3);
        chk("R3 step three words", wv(13, 1), 1'b0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R8 idle hold", wv(13, 1), 1'b0);
    endtask

    task automatic t_cross;
        cyc(0, 1, 0, 254, 2);
        chk("R2 full tap 254", wv(254, 2), 1'b0);
        adv_n(1);
        chk("R3 step to 255", wv(255, 2), 1'b0);
        adv_n(1);
        chk("R4 low to high without offset", wv(256, 2), 1'b1);
        cyc(0, 1, 0, 511, 3);
        chk("R2 full tap 511 high half", wv(511, 3), 1'b1);
        adv_n(1);
        chk("R4 wrap 511 to 0", wv(0, 3), 1'b0);
    endtask

    task automatic t_split;
        cyc(0, 1, 0, 250, 4);
        cyc(0, 0, 1, 9'h105, 5);
        chk("R5 split keeps active word", wv(250, 4), 1'b0);
        adv_n(5);
        chk("R5 active half data intact", wv(255, 4), 1'b0);
        adv_n(1);
        chk("R4 enter high at split offset 5", wv(261, 5), 1'b1);
        adv_n(250);
        chk("R5 high half loaded", wv(511, 5), 1'b1);
        adv_n(1);
        chk("R4 high to low at first word", wv(0, 4), 1'b0);
        adv_n(255);
        chk("R5 low half never reloaded", wv(255, 4), 1'b0);
        adv_n(1);
        chk("R9 offset used once", wv(256, 5), 1'b1);
    endtask

    task automatic t_collide;
        cyc(0, 1, 0, 255, 6);
        cyc(1, 0, 1, 3, 7);
        chk("R6 advance first, high keeps old row", wv(256, 6), 1'b1);
        adv_n(255);
        chk("R6 high half untouched", wv(511, 6), 1'b1);
        adv_n(1);
        chk("R6 low half loaded at offset 3", wv(3, 7), 1'b0);
    endtask

    task automatic t_priority;
        cyc(0, 1, 0, 100, 8);
        cyc(1, 1, 1, 300, 9);
        chk("R7 full wins over strobe", wv(300, 9), 1'b1);
        adv_n(211);
        chk("R7 stream after full", wv(511, 9), 1'b1);
        adv_n(1);
        chk("R7 split ignored, no offset", wv(0, 9), 1'b0);
    endtask

    task automatic t_full_clears;
        cyc(0, 1, 0, 0, 11);
        cyc(0, 0, 1, 20, 12);
        cyc(0, 1, 0, 255, 13);
        chk("R2 full after split", wv(255, 13), 1'b0);
        adv_n(1);
        chk("R2 full discards pending offset", wv(256, 13), 1'b1);
    endtask

    initial begin
        rst_n      = 1'b0;
        shift_en   = 1'b0;
        xfer_full  = 1'b0;
        xfer_split = 1'b0;
        xfer_tap   = '0;
        row_data   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_full_step;
        t_cross;
        t_split;
        t_collide;
        t_priority;
        t_full_clears;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule